// File: doc/BRIEF.md
# File Server Command Requester

This block sits on the host side of a file-access server and turns simple client requests into the byte-wide command protocol the server understands. A client asks for the next or previous directory entry, for a read of N 32-bit words, or for a forward or backward seek of N blocks of 1024 words. The requester drives an 8-bit input bus with a valid strobe and a control bit: control low marks a parameter byte and control high marks a command byte. A byte goes out only while the server reports that it is not busy. Read and seek requests send their size parameter first, encoded as N minus one, and then the command.

The server returns 32-bit words on its own output bus with a valid strobe. The strobe may drop between words. The server gives no end-of-transfer marker, so the requester counts the words it receives and decides on its own when a transfer is complete. Each received word is forwarded to the client one cycle later, and a one-cycle done pulse marks the end of every request. For directory-entry requests the block also keeps the 11-byte space-padded 8.3 name, the directory flag and the file size from the returned entry.

Top module: `fileCmdRequester`

## Requirements
- R1: After reset, reqReady is 1 and busIValid, wordValid and done are all 0.
- R2: For a read or seek request, one parameter byte with busICtrl=0 and value equal to reqSize (the word or block count minus one) is sent before the command byte. Entry requests send no parameter byte.
- R3: busIValid is 1 only in cycles where srvBusy is 0. A pending byte waits for as long as srvBusy stays high, including between the parameter and the command.
- R4: The command byte (busICtrl=1) is 0x00 for the next entry (reqKind=0), 0x01 for the previous entry (reqKind=1), 0x02 for a read (reqKind=2), and for a seek (reqKind=3) 0x04 forward (reqBackward=0) or 0x05 backward (reqBackward=1). Code 0x03 and codes above 0x05 are never sent.
- R5: Each cycle with busOValid=1 during a transfer produces wordValid=1 with the same word on wordData in the next cycle. Word order is kept, and gaps in busOValid produce gaps in wordValid.
- R6: An entry transfer ends after exactly 8 words and a read ends after reqSize+1 words. done is 1 in the same cycle as wordValid for the last word.
- R7: A seek returns no words. done rises in the cycle after the command byte is accepted, and wordValid stays 0.
- R8: busOValid=1 outside a transfer (while the parameter or command is pending, or after the last word) has no effect: wordValid stays 0.
- R9: reqValid is ignored while reqReady is 0, and no byte is sent on busI while the requester is idle.
- R10: After an entry transfer, entryName holds bytes 0 to 10 of the entry with byte k at bits [8k+7:8k]. entryIsDir is bit 1 of byte 11, and entrySize is word 7. Read and seek requests leave these outputs unchanged.
- R11: done lasts exactly one cycle, and reqReady is 1 again in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Client request strobe, taken when reqReady is 1 |
| reqKind | input | 2 | 0 next entry, 1 previous entry, 2 read, 3 seek |
| reqBackward | input | 1 | Seek direction, 1 = backward |
| reqSize | input | 8 | Word or block count minus one |
| reqReady | output | 1 | Requester idle and accepting a request |
| done | output | 1 | One-cycle end-of-request pulse |
| busI | output | 8 | Parameter or command byte to the server |
| busIValid | output | 1 | busI carries a byte this cycle |
| busICtrl | output | 1 | 1 = command byte, 0 = parameter byte |
| srvBusy | input | 1 | Server cannot take a byte |
| busO | input | 32 | Word returned by the server |
| busOValid | input | 1 | busO is valid this cycle |
| wordValid | output | 1 | Forwarded word valid |
| wordData | output | 32 | Forwarded word |
| entryName | output | 88 | 8.3 name of the last fetched entry |
| entryIsDir | output | 1 | Directory flag of the last fetched entry |
| entrySize | output | 32 | File size of the last fetched entry |

## Verification
Assertions check four things on every cycle: a byte is never presented while the server is busy, only legal command codes appear, done never lasts longer than one cycle, and the word counter never takes a word when no words remain. The following can only be shown by the bench scenarios: the exact transfer length for every read size from 1 to 256 words, the alignment of done with the last forwarded word under irregular gaps, the extraction of the name, directory flag and size fields, and the fact that stray requests and stray server words leave no trace.

// File: rtl/fileCmdPkg.sv
package fileCmdPkg;

  typedef enum logic [1:0] {
    KIND_NEXT = 2'd0,
    KIND_PREV = 2'd1,
    KIND_READ = 2'd2,
    KIND_SEEK = 2'd3
  } reqKind_t;

  localparam logic [7:0] CMD_NEXT = 8'h00;
  localparam logic [7:0] CMD_PREV = 8'h01;
  localparam logic [7:0] CMD_READ = 8'h02;
  localparam logic [7:0] CMD_OPEN = 8'h03;
  localparam logic [7:0] CMD_FWD  = 8'h04;
  localparam logic [7:0] CMD_BWD  = 8'h05;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PARAM,
    ST_CMD,
    ST_COLLECT,
    ST_DONE
  } state_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadReq;    // accept a new request this cycle
    logic loadEntry;  // the accepted request is an entry fetch
    logic takeWord;   // a returned word is consumed this cycle
  } dpStrobe_t;

endpackage

// File: rtl/fileCmdCtrl.sv
module fileCmdCtrl
  import fileCmdPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic              reqBackward,
  input  logic [BYTE_W-1:0] reqSize,
  input  logic              srvBusy,
  input  logic              busOValid,
  input  logic              lastWord,
  output logic              reqReady,
  output logic              done,
  output logic [BYTE_W-1:0] busI,
  output logic              busIValid,
  output logic              busICtrl,
  output dpStrobe_t         strobe
);

  state_t            state, stateN;
  reqKind_t          kindQ;
  logic              backQ;
  logic [BYTE_W-1:0] sizeQ;
  logic [BYTE_W-1:0] cmdCode;
  reqKind_t          kindIn;

  assign kindIn = reqKind_t'(reqKind);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kindQ <= KIND_NEXT;
      backQ <= 1'b0;
      sizeQ <= '0;
    end else begin
      state <= stateN;
      if (state == ST_IDLE && reqValid) begin
        kindQ <= kindIn;
        backQ <= reqBackward;
        sizeQ <= reqSize;
      end
    end
  end

  always_comb begin
    unique case (kindQ)
      KIND_NEXT: cmdCode = BYTE_W'(CMD_NEXT);
      KIND_PREV: cmdCode = BYTE_W'(CMD_PREV);
      KIND_READ: cmdCode = BYTE_W'(CMD_READ);
      default:   cmdCode = backQ ? BYTE_W'(CMD_BWD) : BYTE_W'(CMD_FWD);
    endcase
  end

  always_comb begin
    stateN = state;
    unique case (state)
      ST_IDLE:
        if (reqValid)
          stateN = (kindIn == KIND_READ || kindIn == KIND_SEEK) ? ST_PARAM : ST_CMD;
      ST_PARAM:
        if (!srvBusy) stateN = ST_CMD;
      ST_CMD:
        if (!srvBusy) stateN = (kindQ == KIND_SEEK) ? ST_DONE : ST_COLLECT;
      ST_COLLECT:
        if (busOValid && lastWord) stateN = ST_DONE;
      ST_DONE:
        stateN = ST_IDLE;
      default:
        stateN = ST_IDLE;
    endcase
  end

  assign reqReady  = (state == ST_IDLE);
  assign done      = (state == ST_DONE);
  assign busIValid = (state == ST_PARAM || state == ST_CMD) && !srvBusy;
  assign busICtrl  = (state == ST_CMD);
  assign busI      = (state == ST_PARAM) ? sizeQ : cmdCode;

  assign strobe.loadReq   = (state == ST_IDLE) && reqValid;
  assign strobe.loadEntry = (kindIn == KIND_NEXT) || (kindIn == KIND_PREV);
  assign strobe.takeWord  = (state == ST_COLLECT) && busOValid;

  AST_BUSY_GATE: assert property (@(posedge clk) disable iff (!rstN)
    busIValid |-> !srvBusy); // R3

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (busIValid && busICtrl) |-> (busI <= BYTE_W'(CMD_BWD) && busI != BYTE_W'(CMD_OPEN))); // R4

  AST_PARAM_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (busIValid && !busICtrl) |=> !(busIValid && !busICtrl)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busIValid); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && reqReady)); // R11

endmodule

// File: rtl/fileCmdData.sv
module fileCmdData
  import fileCmdPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int BYTE_W      = 8,
  parameter int ENTRY_WORDS = 8,
  parameter int NAME_BYTES  = 11,
  parameter int DIR_BIT     = 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobe_t                    strobe,
  input  logic [BYTE_W-1:0]            reqSize,
  input  logic [DATA_W-1:0]            busO,
  output logic                         lastWord,
  output logic                         wordValid,
  output logic [DATA_W-1:0]            wordData,
  output logic [NAME_BYTES*BYTE_W-1:0] entryName,
  output logic                         entryIsDir,
  output logic [DATA_W-1:0]            entrySize
);

  localparam int LANES     = DATA_W / BYTE_W;
  localparam int CNT_W     = BYTE_W + 1;
  localparam int ATTR_WORD = NAME_BYTES / LANES;
  localparam int ATTR_LANE = NAME_BYTES % LANES;

  logic [CNT_W-1:0]  remain;
  logic [CNT_W-1:0]  wordIdx;
  logic              isEntryQ;
  logic              capture;
  logic [BYTE_W-1:0] nameQ    [NAME_BYTES];
  logic [BYTE_W-1:0] nameNext [NAME_BYTES];

  assign lastWord = (remain == CNT_W'(1));
  assign capture  = strobe.takeWord && isEntryQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain    <= '0;
      wordIdx   <= '0;
      isEntryQ  <= 1'b0;
      wordValid <= 1'b0;
      wordData  <= '0;
    end else begin
      wordValid <= strobe.takeWord;
      if (strobe.takeWord) wordData <= busO;
      if (strobe.loadReq) begin
        isEntryQ <= strobe.loadEntry;
        wordIdx  <= '0;
        remain   <= strobe.loadEntry ? CNT_W'(ENTRY_WORDS)
                                     : ({1'b0, reqSize} + CNT_W'(1));
      end else if (strobe.takeWord) begin
        wordIdx <= wordIdx + CNT_W'(1);
        remain  <= remain - CNT_W'(1);
      end
    end
  end

  for (genvar k = 0; k < NAME_BYTES; k++) begin : g_name
    assign nameNext[k] = (capture && wordIdx == CNT_W'(k / LANES))
                         ? busO[(k % LANES)*BYTE_W +: BYTE_W] : nameQ[k];
    assign entryName[k*BYTE_W +: BYTE_W] = nameQ[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NAME_BYTES; k++) nameQ[k] <= '0;
      entryIsDir <= 1'b0;
      entrySize  <= '0;
    end else begin
      nameQ <= nameNext;
      if (capture && wordIdx == CNT_W'(ATTR_WORD))
        entryIsDir <= busO[ATTR_LANE*BYTE_W + DIR_BIT];
      if (capture && wordIdx == CNT_W'(ENTRY_WORDS - 1))
        entrySize <= busO;
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeWord |-> (remain != '0)); // R6

  AST_ENTRY_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    capture |-> (wordIdx < CNT_W'(ENTRY_WORDS))); // R6

endmodule

// File: rtl/fileCmdRequester.sv
module fileCmdRequester
  import fileCmdPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int BYTE_W      = 8,
  parameter int ENTRY_WORDS = 8,
  parameter int NAME_BYTES  = 11
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  input  logic [1:0]                   reqKind,
  input  logic                         reqBackward,
  input  logic [BYTE_W-1:0]            reqSize,
  output logic                         reqReady,
  output logic                         done,
  output logic [BYTE_W-1:0]            busI,
  output logic                         busIValid,
  output logic                         busICtrl,
  input  logic                         srvBusy,
  input  logic [DATA_W-1:0]            busO,
  input  logic                         busOValid,
  output logic                         wordValid,
  output logic [DATA_W-1:0]            wordData,
  output logic [NAME_BYTES*BYTE_W-1:0] entryName,
  output logic                         entryIsDir,
  output logic [DATA_W-1:0]            entrySize
);

  dpStrobe_t strobe;
  logic      lastWord;

  fileCmdCtrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqKind(reqKind), .reqBackward(reqBackward), .reqSize(reqSize),
    .srvBusy(srvBusy), .busOValid(busOValid), .lastWord(lastWord),
    .reqReady(reqReady), .done(done),
    .busI(busI), .busIValid(busIValid), .busICtrl(busICtrl),
    .strobe(strobe)
  );

  fileCmdData #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .ENTRY_WORDS(ENTRY_WORDS), .NAME_BYTES(NAME_BYTES)
  ) u_data (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .reqSize(reqSize), .busO(busO),
    .lastWord(lastWord), .wordValid(wordValid), .wordData(wordData),
    .entryName(entryName), .entryIsDir(entryIsDir), .entrySize(entrySize)
  );

endmodule

// File: tb/fileCmdRequester_tb.sv
module fileCmdRequester_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [1:0]  reqKind;
  logic        reqBackward;
  logic [7:0]  reqSize;
  logic        reqReady, done, busIValid, busICtrl;
  logic [7:0]  busI;
  logic        srvBusy;
  logic [31:0] busO;
  logic        busOValid;
  logic        wordValid;
  logic [31:0] wordData;
  logic [87:0] entryName;
  logic        entryIsDir;
  logic [31:0] entrySize;

  int nChecks = 0;
  int nFails  = 0;

  logic [87:0] expName = '0;
  logic        expDir  = 1'b0;
  logic [31:0] expSize = '0;

  always #5 clk = ~clk;

  fileCmdRequester u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqBackward(reqBackward), .reqSize(reqSize), .reqReady(reqReady), .done(done),
    .busI(busI), .busIValid(busIValid), .busICtrl(busICtrl), .srvBusy(srvBusy),
    .busO(busO), .busOValid(busOValid), .wordValid(wordValid), .wordData(wordData),
    .entryName(entryName), .entryIsDir(entryIsDir), .entrySize(entrySize)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] entByte(input int seed, input int k, input bit dir);
    logic [31:0] sz;
    sz = 32'(seed) * 32'd1000 + 32'd7;
    if (k < 11)       return 8'h41 + 8'((seed + k) % 26);
    else if (k == 11) return dir ? 8'h12 : 8'h20;
    else if (k >= 28) return sz[(k-28)*8 +: 8];
    else              return 8'((seed * k) & 8'hff);
  endfunction

  function automatic logic [31:0] wordOf(input bit isEntry, input int seed, input int i, input bit dir);
    logic [31:0] w;
    if (isEntry) begin
      for (int b = 0; b < 4; b++) w[b*8 +: 8] = entByte(seed, 4*i + b, dir);
    end else begin
      w = {16'(seed) ^ 16'hA5A5, 16'(i)};
    end
    return w;
  endfunction

  task automatic doRequest(input int kind, input bit back, input int size, input int seed,
                           input bit dir, input int b0, input int b1, input bit gapSel);
    bit   needParam = (kind >= 2);
    bit   isEntry   = (kind < 2);
    bit   paramSeen = 0;
    bit   cmdSeen   = 0;
    int   busyCnt   = b0;
    int   guard     = 0;
    int   nWords;
    logic [7:0] expCode;
    expCode = (kind == 0) ? 8'h00 : (kind == 1) ? 8'h01 : (kind == 2) ? 8'h02 : (back ? 8'h05 : 8'h04);
    nWords  = isEntry ? 8 : size + 1;

    @(negedge clk);
    check(reqReady == 1'b1, "R11 ready before request", reqReady, 1);
    reqValid = 1'b1; reqKind = 2'(kind); reqBackward = back; reqSize = 8'(size);
    srvBusy = (busyCnt > 0);
    busOValid = 1'b1; busO = 32'hDEAD_BEEF;

    while (!cmdSeen && guard < 40) begin
      @(negedge clk);
      guard++;
      if (guard == 1) check(reqReady == 1'b0, "R9 not ready while busy", reqReady, 0);
      reqValid = (guard == 1);  // second pulse while not ready: must be ignored
      reqKind  = 2'd2;
      check(wordValid == 1'b0, "R8 stray word before command", wordValid, 0);
      if (busyCnt > 0) busyCnt--;
      srvBusy = (busyCnt > 0);
      #1;
      if (srvBusy) check(busIValid == 1'b0, "R3 byte held while busy", busIValid, 0);
      if (busIValid && !busICtrl) begin
        check(needParam && !paramSeen, "R2 unexpected parameter", paramSeen, 0);
        check(busI == 8'(size), "R2 parameter value", busI, 8'(size));
        paramSeen = 1;
        busyCnt = b1 + 1;
      end else if (busIValid && busICtrl) begin
        check(paramSeen == needParam, "R2 parameter before command", paramSeen, needParam);
        check(busI == expCode, "R4 command code", busI, expCode);
        cmdSeen = 1;
      end
    end
    reqValid = 1'b0;
    check(cmdSeen, "R3 command issued", cmdSeen, 1);

    if (kind == 3) begin
      @(negedge clk);
      busOValid = 1'b0; srvBusy = 1'b0;
      check(done == 1'b1, "R7 seek done", done, 1);
      check(wordValid == 1'b0, "R7 seek no words", wordValid, 0);
      @(negedge clk);
      check(done == 1'b0, "R11 done single", done, 0);
    end else begin
      @(negedge clk);
      srvBusy = 1'b0;
      check(wordValid == 1'b0, "R8 stray word at command", wordValid, 0);
      for (int i = 0; i < nWords; i++) begin
        int g = gapSel ? ((i * 7 + size) % 3) : 0;
        for (int j = 0; j < g; j++) begin
          busOValid = 1'b0;
          @(negedge clk);
          check(wordValid == 1'b0 && done == 1'b0, "R5 gap", {wordValid, done}, 0);
        end
        busOValid = 1'b1; busO = wordOf(isEntry, seed, i, dir);
        @(negedge clk);
        check(wordValid == 1'b1 && wordData == wordOf(isEntry, seed, i, dir), "R5 forwarded word",
              {wordValid, wordData}, {1'b1, wordOf(isEntry, seed, i, dir)});
        check(done == (i == nWords - 1), "R6 done at last word", done, (i == nWords - 1));
      end
      busO = 32'hBAD0_BAD0;  // stray word after the transfer
      @(negedge clk);
      busOValid = 1'b0;
      check(wordValid == 1'b0, "R8 stray word after done", wordValid, 0);
      check(done == 1'b0 && reqReady == 1'b1, "R11 done single and ready", {done, reqReady}, 2'b01);
      if (isEntry) begin
        for (int k = 0; k < 11; k++) expName[k*8 +: 8] = entByte(seed, k, dir);
        expDir = dir;
        expSize = 32'(seed) * 32'd1000 + 32'd7;
      end
      check(entryName == expName, "R10 entry name", entryName, expName);
      check(entryIsDir == expDir, "R10 directory flag", entryIsDir, expDir);
      check(entrySize == expSize, "R10 file size", entrySize, expSize);
    end
    #1;
    check(busIValid == 1'b0, "R9 idle sends nothing", busIValid, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog R6 transfer never completed");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqKind = 2'd0; reqBackward = 1'b0; reqSize = 8'd0;
    srvBusy = 1'b0; busO = '0; busOValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(reqReady == 1'b1 && busIValid == 1'b0 && wordValid == 1'b0 && done == 1'b0,
          "R1 reset state", {reqReady, busIValid, wordValid, done}, 4'b1000);
    busOValid = 1'b1; busO = 32'h1234_5678;  // stray word while idle
    rstN = 1'b1;
    @(negedge clk);
    busOValid = 1'b0;
    check(wordValid == 1'b0, "R8 stray word while idle", wordValid, 0);

    for (int s = 0; s < 16; s++)
      doRequest(s % 2, 1'b0, 0, s + 3, s[1], s % 3, 0, s[0]);
    for (int p = 0; p < 256; p++) begin
      doRequest(2, 1'b0, p, p, 1'b0, p % 3, (p / 3) % 3, p[0]);
      if (p % 64 == 63) doRequest(p[6], 1'b0, 0, p, p[7], 1, 0, 1'b1);
    end
    for (int q = 0; q < 8; q++)
      doRequest(3, q[0], (q * 37) % 256, q, 1'b0, q % 3, q % 2 + 1, 1'b0);
    doRequest(3, 1'b1, 255, 1, 1'b0, 0, 0, 1'b0);
    doRequest(3, 1'b0, 0, 1, 1'b0, 2, 3, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule